// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block generates the horizontal and vertical position counters for a raster display, together with the blanking and sync strobes derived from them. Each strobe has two 16-bit compare positions. One position turns the strobe on and the other turns it off. Between those two events the strobe keeps its level. This means any porch and pulse layout, including inverted or wrap-around windows, comes from the compare values alone and not from fixed porch lengths.

The horizontal counter runs from zero up to a programmable line total. The vertical counter steps once per line, up to a programmable frame total. Both counters are brought out as ports so that a host can read the beam position. A composite sync strobe is built from the horizontal and vertical sync turn-on events and is forced off at its own horizontal compare position. A one-cycle pulse marks the start of vertical blanking. A video-enable input parks the whole generator: the counters are held at zero, blanking is held on and every sync is held off.

Top module: `raster_timing_gen`

## Requirements
- R1: `h_count` is registered. While enabled, it increments each cycle and returns to 0 on the cycle after it shows `h_total`, so a line lasts `h_total`+1 cycles.
- R2: `v_count` changes only on the cycle after `h_count` equals `h_total`. It then increments, or returns to 0 if it was equal to `v_total`.
- R3: `hblank` goes to 1 on the cycle after `h_count` equals `hblank_on`, and goes to 0 on the cycle after `h_count` equals `hblank_off`. Otherwise it holds its level.
- R4: `hsync` follows the same rule as R3, using `hsync_on` and `hsync_off`.
- R5: `vblank` can change only on the cycle after a cycle in which `h_count` is 0. In that cycle, `v_count` equal to `vblank_on` turns it on and `v_count` equal to `vblank_off` turns it off.
- R6: `vsync` follows the same rule as R5, using `vsync_on` and `vsync_off`.
- R7: `csync` goes to 0 on the cycle after `h_count` equals `csync_off`. Otherwise it goes to 1 on the cycle after an hsync turn-on match or a vsync turn-on match (the latter qualified by `h_count` being 0). Otherwise it holds. The `csync_off` rule has priority.
- R8: `blank` is 1 whenever `hblank` or `vblank` is 1, and is 0 otherwise.
- R9: On the cycle after `video_en` is sampled low, both counters read 0, `hblank` and `vblank` read 1, and `hsync`, `vsync`, `csync` and `vblank_pulse` read 0.
- R10: When an on position and an off position match in the same cycle, the on position wins.
- R11: `vblank_pulse` is 1 for exactly the single cycle in which `vblank` rises from 0 to 1 because of a `vblank_on` match.
- R12: After a synchronous reset (`rst_n` low), the outputs take the same values as in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| video_en | input | 1 | 1 runs the generator, 0 parks it |
| h_total | input | 16 | Last value of the horizontal counter |
| v_total | input | 16 | Last value of the vertical counter |
| hblank_on | input | 16 | Horizontal blank turn-on position |
| hblank_off | input | 16 | Horizontal blank turn-off position |
| hsync_on | input | 16 | Horizontal sync turn-on position |
| hsync_off | input | 16 | Horizontal sync turn-off position |
| vblank_on | input | 16 | Vertical blank turn-on line |
| vblank_off | input | 16 | Vertical blank turn-off line |
| vsync_on | input | 16 | Vertical sync turn-on line |
| vsync_off | input | 16 | Vertical sync turn-off line |
| csync_off | input | 16 | Horizontal position at which composite sync is forced off |
| h_count | output | 16 | Current horizontal position |
| v_count | output | 16 | Current vertical position |
| hblank | output | 1 | Horizontal blank strobe |
| hsync | output | 1 | Horizontal sync strobe |
| vblank | output | 1 | Vertical blank strobe |
| vsync | output | 1 | Vertical sync strobe |
| blank | output | 1 | Combined blank |
| csync | output | 1 | Composite sync |
| vblank_pulse | output | 1 | Single-cycle marker at vertical blank onset |

## Verification
The hardest situations to reach are the ones where several compare values coincide. Examples are an on and an off position that are equal, a composite turn-off that lands inside a sync window, and a frame boundary that falls while the generator is being parked and released. At real display sizes these would take millions of cycles to reach. The stimulus therefore uses tiny line and frame totals, so that each coincidence recurs every few dozen cycles. It programs one configuration with equal on/off positions for horizontal sync. It also drops `video_en` in the middle of a frame, so that the vertical strobes restart from their parked values. A cycle-by-cycle scoreboard compares every output against a model built from the requirements.

// File: rtl/rtg_pkg.sv
// Shared definitions for the raster timing generator.
// Assumes every counter and compare position uses the same width.
package rtg_pkg;
    localparam int CNT_W = 16;

    // Index of each compared strobe; horizontal ones come first
    typedef enum logic [1:0] {
        STB_HBLANK = 2'd0,
        STB_HSYNC  = 2'd1,
        STB_VBLANK = 2'd2,
        STB_VSYNC  = 2'd3
    } strobe_e;

    localparam int NUM_STB = 4;
endpackage

// File: rtl/rtg_counter.sv
// Horizontal and vertical beam position counters.
// Assumes h_total and v_total are held stable while the generator runs.
// While disabled, both counters are parked at zero.
module rtg_counter #(
    parameter int CW = rtg_pkg::CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [CW-1:0] h_total,
    input  logic [CW-1:0] v_total,
    output logic [CW-1:0] h_cnt,
    output logic [CW-1:0] v_cnt
);
    logic line_end;
    logic frame_end;

    // Detect the last pixel of a line and the last line of a frame
    always_comb begin
        line_end  = (h_cnt == h_total);
        frame_end = (v_cnt == v_total);
    end

    // Horizontal position: count up, wrap at the line total
    always_ff @(posedge clk) begin
        if (!rst_n || !en)
            h_cnt <= '0;
        else if (line_end)
            h_cnt <= '0;
        else
            h_cnt <= h_cnt + 1'b1;
    end

    // Vertical position: step once per line, wrap at the frame total
    always_ff @(posedge clk) begin
        if (!rst_n || !en)
            v_cnt <= '0;
        else if (line_end)
            v_cnt <= frame_end ? '0 : v_cnt + 1'b1;
    end
endmodule

// File: rtl/rtg_edge_flop.sv
// Single strobe driven by a turn-on compare and a turn-off compare.
// Assumes the caller supplies the counter to compare and a qualifier that
// says in which cycles the compare counts. The turn-on match has priority.
// When disabled or in reset, the strobe sits at IDLE.
module rtg_edge_flop #(
    parameter int   CW   = rtg_pkg::CNT_W,
    parameter logic IDLE = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          qual,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] on_pos,
    input  logic [CW-1:0] off_pos,
    output logic          q,
    output logic          on_evt
);
    logic off_evt;

    // Qualified compare events for this cycle
    always_comb begin
        on_evt  = qual && (cnt == on_pos);
        off_evt = qual && (cnt == off_pos);
    end

    // Strobe state: the turn-on event wins, otherwise the turn-off event, otherwise hold
    always_ff @(posedge clk) begin
        if (!rst_n || !en)
            q <= IDLE;
        else if (on_evt)
            q <= 1'b1;
        else if (off_evt)
            q <= 1'b0;
    end
endmodule

// File: rtl/rtg_csync.sv
// Composite sync and vertical-blank onset pulse.
// Assumes the turn-on events come from the sync edge flops in the same cycle.
// Composite sync is forced off at its own position; that rule beats any turn-on event.
module rtg_csync (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic hs_on_evt,
    input  logic vs_on_evt,
    input  logic cs_off_hit,
    input  logic vb_on_evt,
    input  logic vb_level,
    output logic csync,
    output logic vb_pulse
);
    // Composite sync state
    always_ff @(posedge clk) begin
        if (!rst_n || !en)
            csync <= 1'b0;
        else if (cs_off_hit)
            csync <= 1'b0;
        else if (hs_on_evt || vs_on_evt)
            csync <= 1'b1;
    end

    // One-cycle marker when vertical blank is about to rise from low
    always_ff @(posedge clk) begin
        if (!rst_n || !en)
            vb_pulse <= 1'b0;
        else
            vb_pulse <= vb_on_evt && !vb_level;
    end
endmodule

// File: rtl/raster_timing_gen.sv
// Programmable raster timing generator top level.
// Assumes all position inputs are quasi-static configuration values.
// It instantiates the counters, one edge flop per strobe, and the composite-sync logic.
// Vertical strobes are qualified by the first pixel of each line.
module raster_timing_gen #(
    parameter int CW = rtg_pkg::CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          video_en,
    input  logic [CW-1:0] h_total,
    input  logic [CW-1:0] v_total,
    input  logic [CW-1:0] hblank_on,
    input  logic [CW-1:0] hblank_off,
    input  logic [CW-1:0] hsync_on,
    input  logic [CW-1:0] hsync_off,
    input  logic [CW-1:0] vblank_on,
    input  logic [CW-1:0] vblank_off,
    input  logic [CW-1:0] vsync_on,
    input  logic [CW-1:0] vsync_off,
    input  logic [CW-1:0] csync_off,
    output logic [CW-1:0] h_count,
    output logic [CW-1:0] v_count,
    output logic          hblank,
    output logic          hsync,
    output logic          vblank,
    output logic          vsync,
    output logic          blank,
    output logic          csync,
    output logic          vblank_pulse
);
    import rtg_pkg::*;

    logic [CW-1:0] on_arr  [NUM_STB];
    logic [CW-1:0] off_arr [NUM_STB];
    logic [NUM_STB-1:0] stb_q;
    logic [NUM_STB-1:0] stb_on_evt;
    logic line_start;
    logic cs_off_hit;

    rtg_counter #(.CW(CW)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (video_en),
        .h_total (h_total),
        .v_total (v_total),
        .h_cnt   (h_count),
        .v_cnt   (v_count)
    );

    // Gather the compare positions into arrays indexed by strobe
    always_comb begin
        on_arr[STB_HBLANK]  = hblank_on;
        off_arr[STB_HBLANK] = hblank_off;
        on_arr[STB_HSYNC]   = hsync_on;
        off_arr[STB_HSYNC]  = hsync_off;
        on_arr[STB_VBLANK]  = vblank_on;
        off_arr[STB_VBLANK] = vblank_off;
        on_arr[STB_VSYNC]   = vsync_on;
        off_arr[STB_VSYNC]  = vsync_off;
        line_start          = (h_count == '0);
        cs_off_hit          = (h_count == csync_off);
    end

    for (genvar i = 0; i < NUM_STB; i++) begin : g_stb
        localparam bit   IS_VERT  = (i >= 2);
        localparam logic IDLE_LVL = (i == int'(STB_HBLANK)) || (i == int'(STB_VBLANK));
        rtg_edge_flop #(.CW(CW), .IDLE(IDLE_LVL)) u_edge (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (video_en),
            .qual    (IS_VERT ? line_start : 1'b1),
            .cnt     (IS_VERT ? v_count : h_count),
            .on_pos  (on_arr[i]),
            .off_pos (off_arr[i]),
            .q       (stb_q[i]),
            .on_evt  (stb_on_evt[i])
        );
    end

    rtg_csync u_cs (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (video_en),
        .hs_on_evt  (stb_on_evt[STB_HSYNC]),
        .vs_on_evt  (stb_on_evt[STB_VSYNC]),
        .cs_off_hit (cs_off_hit),
        .vb_on_evt  (stb_on_evt[STB_VBLANK]),
        .vb_level   (stb_q[STB_VBLANK]),
        .csync      (csync),
        .vb_pulse   (vblank_pulse)
    );

    // Drive the named strobe outputs and the combined blank
    always_comb begin
        hblank = stb_q[STB_HBLANK];
        hsync  = stb_q[STB_HSYNC];
        vblank = stb_q[STB_VBLANK];
        vsync  = stb_q[STB_VSYNC];
        blank  = stb_q[STB_HBLANK] | stb_q[STB_VBLANK];
    end
endmodule

// File: rtl/rtg_checker.sv
// Temporal properties of the raster timing generator, bound to its top level.
module rtg_checker #(
    parameter int CW = rtg_pkg::CNT_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic          video_en,
    input logic [CW-1:0] h_total,
    input logic [CW-1:0] hblank_on,
    input logic [CW-1:0] hsync_on,
    input logic [CW-1:0] hsync_off,
    input logic [CW-1:0] csync_off,
    input logic [CW-1:0] h_count,
    input logic [CW-1:0] v_count,
    input logic          hblank,
    input logic          hsync,
    input logic          vblank,
    input logic          blank,
    input logic          csync,
    input logic          vblank_pulse
);
    assert_hwrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (video_en && h_count == h_total) |=> (h_count == '0));

    assert_hstep_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (video_en && h_count != h_total) |=> (h_count == $past(h_count) + 1'b1));

    assert_vhold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (video_en && h_count != h_total) |=> $stable(v_count));

    assert_hblank_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (video_en && h_count == hblank_on) |=> hblank);

    assert_hsync_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (video_en && h_count == hsync_off && h_count != hsync_on) |=> !hsync);

    assert_vblank_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (video_en && h_count != '0) |=> $stable(vblank));

    assert_csync_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (video_en && h_count == csync_off) |=> !csync);

    assert_blank_cover_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hblank || vblank) |-> blank);

    assert_parked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !video_en |=> (h_count == '0 && v_count == '0 && blank && !csync && !hsync));

    assert_onwins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (video_en && h_count == hsync_on) |=> hsync);

    assert_pulse_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
        vblank_pulse |-> vblank);

    assert_pulse_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        vblank_pulse |=> !vblank_pulse);
endmodule

bind raster_timing_gen rtg_checker #(.CW(CW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .video_en     (video_en),
    .h_total      (h_total),
    .hblank_on    (hblank_on),
    .hsync_on     (hsync_on),
    .hsync_off    (hsync_off),
    .csync_off    (csync_off),
    .h_count      (h_count),
    .v_count      (v_count),
    .hblank       (hblank),
    .hsync        (hsync),
    .vblank       (vblank),
    .blank        (blank),
    .csync        (csync),
    .vblank_pulse (vblank_pulse)
);

// File: tb/sim_raster_timing_gen.sv
`timescale 1ns/1ps
module sim_raster_timing_gen;
    localparam int CW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic video_en = 1'b0;
    logic [CW-1:0] h_total = '0, v_total = '0;
    logic [CW-1:0] hblank_on = '0, hblank_off = '0, hsync_on = '0, hsync_off = '0;
    logic [CW-1:0] vblank_on = '0, vblank_off = '0, vsync_on = '0, vsync_off = '0;
    logic [CW-1:0] csync_off = '0;
    logic [CW-1:0] h_count, v_count;
    logic hblank, hsync, vblank, vsync, blank, csync, vblank_pulse;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    typedef struct {
        int hc; int vc;
        bit hb; bit hs; bit vb; bit vs; bit cs; bit pl;
    } exp_t;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    raster_timing_gen #(.CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .video_en(video_en),
        .h_total(h_total), .v_total(v_total),
        .hblank_on(hblank_on), .hblank_off(hblank_off),
        .hsync_on(hsync_on), .hsync_off(hsync_off),
        .vblank_on(vblank_on), .vblank_off(vblank_off),
        .vsync_on(vsync_on), .vsync_off(vsync_off),
        .csync_off(csync_off),
        .h_count(h_count), .v_count(v_count),
        .hblank(hblank), .hsync(hsync), .vblank(vblank), .vsync(vsync),
        .blank(blank), .csync(csync), .vblank_pulse(vblank_pulse)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Reference model: predicts the state after each edge and pushes it to the scoreboard
    int  mh = 0, mv = 0;
    bit  mhb = 1, mhs = 0, mvb = 1, mvs = 0, mcs = 0, mpl = 0;
    always @(posedge clk) begin
        int  nh, nv;
        bit  nhb, nhs, nvb, nvs, ncs, npl, first;
        cycles++;
        if (!rst_n || !video_en) begin
            nh = 0; nv = 0; nhb = 1; nhs = 0; nvb = 1; nvs = 0; ncs = 0; npl = 0;
        end else begin
            first = (mh == 0);
            nh = (mh == int'(h_total)) ? 0 : mh + 1;
            nv = mv;
            if (mh == int'(h_total)) nv = (mv == int'(v_total)) ? 0 : mv + 1;
            nhb = mhb; nhs = mhs; nvb = mvb; nvs = mvs; ncs = mcs;
            if (mh == int'(hblank_on)) nhb = 1; else if (mh == int'(hblank_off)) nhb = 0;
            if (mh == int'(hsync_on))  nhs = 1; else if (mh == int'(hsync_off))  nhs = 0;
            if (first) begin
                if (mv == int'(vblank_on)) nvb = 1; else if (mv == int'(vblank_off)) nvb = 0;
                if (mv == int'(vsync_on))  nvs = 1; else if (mv == int'(vsync_off))  nvs = 0;
            end
            if (mh == int'(csync_off)) ncs = 0;
            else if (mh == int'(hsync_on) || (first && mv == int'(vsync_on))) ncs = 1;
            npl = first && (mv == int'(vblank_on)) && !mvb;
        end
        mh = nh; mv = nv; mhb = nhb; mhs = nhs; mvb = nvb; mvs = nvs; mcs = ncs; mpl = npl;
        sb_q.push_back('{hc: nh, vc: nv, hb: nhb, hs: nhs, vb: nvb, vs: nvs, cs: ncs, pl: npl});
    end

    // Monitor: compares outputs against the scoreboard away from the active edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            chk(int'(h_count) == e.hc, "R1 h_count", int'(h_count), e.hc);
            chk(int'(v_count) == e.vc, "R2 v_count", int'(v_count), e.vc);
            chk(hblank == e.hb, "R3 hblank", int'(hblank), int'(e.hb));
            chk(hsync  == e.hs, "R4 hsync",  int'(hsync),  int'(e.hs));
            chk(vblank == e.vb, "R5 vblank", int'(vblank), int'(e.vb));
            chk(vsync  == e.vs, "R6 vsync",  int'(vsync),  int'(e.vs));
            chk(csync  == e.cs, "R7 csync",  int'(csync),  int'(e.cs));
            chk(blank  == (e.hb | e.vb), "R8 blank", int'(blank), int'(e.hb | e.vb));
            chk(vblank_pulse == e.pl, "R11 vblank_pulse", int'(vblank_pulse), int'(e.pl));
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary
    always @(posedge clk) begin
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog expired at cycle %0d", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic cfg_a();
        h_total = 16'd9;  v_total = 16'd5;
        hblank_on = 16'd7; hblank_off = 16'd1;
        hsync_on = 16'd8;  hsync_off = 16'd0;
        vblank_on = 16'd4; vblank_off = 16'd0;
        vsync_on = 16'd4;  vsync_off = 16'd5;
        csync_off = 16'd5;
    endtask

    task automatic cfg_b();
        h_total = 16'd4;  v_total = 16'd2;
        hblank_on = 16'd3; hblank_off = 16'd0;
        hsync_on = 16'd1;  hsync_off = 16'd1;
        vblank_on = 16'd2; vblank_off = 16'd0;
        vsync_on = 16'd1;  vsync_off = 16'd2;
        csync_off = 16'd2;
    endtask

    initial begin
        cfg_a();
        wait_cycles(3);
        // R12: reset values
        chk(h_count == '0 && v_count == '0, "R12 reset counters", int'(h_count), 0);
        chk(blank && hblank && vblank, "R12 reset blank", int'(blank), 1);
        chk(!hsync && !vsync && !csync && !vblank_pulse, "R12 reset syncs",
            int'(hsync | vsync | csync | vblank_pulse), 0);
        rst_n = 1'b1;
        wait_cycles(5);
        // Parked: counters at zero, blank held on
        chk(h_count == '0 && blank, "R9 parked after reset", int'(h_count), 0);
        video_en = 1'b1;
        wait_cycles(200);
        video_en = 1'b0;
        wait_cycles(15);
        chk(h_count == '0 && v_count == '0, "R9 disabled counters", int'(h_count) + int'(v_count), 0);
        chk(blank == 1'b1 && csync == 1'b0, "R9 disabled strobes", int'(blank), 1);
        cfg_b();
        video_en = 1'b1;
        wait_cycles(80);
        // R10: hsync on and off share a position; the on match must win
        chk(hsync == 1'b1, "R10 on beats off", int'(hsync), 1);
        cfg_a();
        video_en = 1'b0;
        wait_cycles(2);
        video_en = 1'b1;
        wait_cycles(37);
        video_en = 1'b0;
        wait_cycles(3);
        video_en = 1'b1;
        wait_cycles(130);
        rst_n = 1'b0;
        wait_cycles(2);
        chk(h_count == '0 && blank && !csync, "R12 reset mid-run", int'(h_count), 0);
        wait_cycles(2);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule